// File: doc/BRIEF.md
# Linear Flash Read Line Buffer

This block answers 32-bit memory-mapped reads from a serial flash out of one line buffer holding 256 words (1 KB). A read that falls inside the buffered line is answered straight from the buffer. Any other read starts a complete flash read transaction on a byte-wide transfer engine. The transaction is a command header built from a configuration register, followed by 1024 data bytes that refill the whole line. The read is answered once the line is in place, and the address of that read becomes the new base of the line.

The transfer engine is reached through a start/done handshake that carries one byte each way. The block asks for one byte at a time, and a byte counts as finished when the engine raises done with the received byte. While a transaction is running, exactly one active-low chip select is held low. The select is chosen from the upper bits of the flash address. In dual-bus mode the flash address is the access address halved. Read requests are held off with a ready signal for as long as a refill is in progress.

Top module: `flash_line_buf`

## Requirements
- R1: A read hits when its word-aligned address A satisfies base <= A <= base + 1020. A hit returns buffer word (A - base)/4 with `rd_valid` high one cycle after acceptance, and starts no flash transaction. Any other address misses.
- R2: Address bits 1:0 are ignored, so only whole 32-bit words are read. A request to A+1 returns the same word as a request to A.
- R3: After reset the line is invalid, so the first read misses. A miss runs exactly one flash transaction. The aligned address of the missed read then becomes the new line base.
- R4: The header starts with the command byte, which is configuration bits 7:0. The three flash address bytes follow, most significant first (bits 23:16, 15:8, 7:0).
- R5: When configuration bit 25 is set, a mode byte taken from configuration bits 23:16 is sent right after the address. When the bit is clear, no mode byte is sent.
- R6: After the address and any mode byte, the header sends zero bytes. Their count is given by configuration bits 10:8. Every byte received during the header is discarded.
- R7: After the header, 1024 bytes are read into the 256 buffer words in order. With configuration bit 26 clear, received byte i of a word lands at bits 8*i+7:8*i.
- R8: With configuration bit 26 set, received byte i of a word lands at bits 8*(3-i)+7:8*(3-i).
- R9: With configuration bit 30 clear, the flash address is the aligned access address. With bit 30 set, it is that address divided by two.
- R10: During a transaction, the chip select numbered by flash address bits 31:24 is low and all other selects are high. The selection does not change within a transaction. Outside transactions, all selects are high.
- R11: `rd_ready` is low from the cycle after a miss is accepted until the miss is answered. A request held during that time is accepted afterwards and answered from the new line.
- R12: The configuration register resets to 0x03A002EB, so the default command byte is 0xEB. A new byte is started only after the previous one has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Writes `cfg_wdata` into the configuration register |
| cfg_wdata | input | 32 | New configuration value |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_ready | output | 1 | Request accepted this cycle when high |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | 32 | Read data |
| spi_start | output | 1 | Starts one byte transfer on the engine |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | Engine finished the byte |
| spi_rx | input | 8 | Byte received with `spi_done` |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The hardest situations to reach are a request that arrives in the middle of a refill and a flash address whose upper byte selects a non-zero chip. Both need a miss of more than a thousand handshakes to be under way first. The bench includes a byte-level flash responder whose data bytes are an arithmetic function of the flash address it was sent. Every buffered word can therefore be predicted exactly. The bench then holds a second request across a full refill, and it programs dual-bus mode with an address above 32 MB so that the halved address lands on select 1. A full sweep of the line and the reads just outside each edge establish where hits end.

// File: rtl/flash_line_buf.sv
`timescale 1ns/1ps
module flash_line_buf #(
  parameter int ADDR_W = 32,
  parameter int LINE_WORDS = 256,
  parameter int NUM_CS = 4,
  parameter int FA_BITS = 24,
  parameter logic [31:0] CFG_RESET = 32'h03A0_02EB
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              spi_start,
  output logic [7:0]        spi_tx,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int WIDX_W = $clog2(LINE_WORDS);
  localparam int BCNT_W = WIDX_W + 2;
  localparam int CSW = ADDR_W - FA_BITS;
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'((LINE_WORDS - 1) * 4);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_RESP} state_t;

  state_t            state;
  logic [31:0]       cfg, lcfg;
  logic [ADDR_W-1:0] base, addr_q, fa_q;
  logic              base_ok, wait_done;
  logic [3:0]        hidx;
  logic [BCNT_W-1:0] bcnt;
  logic [31:0]       wacc, wnext;
  logic [31:0]       mem [LINE_WORDS];

  logic [ADDR_W-1:0] a_al, fa_new;
  logic [ADDR_W:0]   diff;
  logic              hit, accept, xfer, got, last_hdr, last_byte;
  logic [3:0]        hdr_len;
  logic [1:0]        lane;
  logic [WIDX_W-1:0] hit_idx;
  logic              unused_bits;

  assign a_al      = {rd_addr[ADDR_W-1:2], 2'b00};
  assign diff      = {1'b0, a_al} - {1'b0, base};
  assign hit       = base_ok && (a_al >= base) && (diff <= SPAN);
  assign hit_idx   = diff[WIDX_W+1:2];
  assign fa_new    = cfg[30] ? (a_al >> 1) : a_al;
  assign rd_ready  = (state == S_IDLE);
  assign accept    = rd_req && rd_ready;
  assign xfer      = (state == S_HDR) || (state == S_DATA);
  assign spi_start = xfer && !wait_done;
  assign got       = xfer && wait_done && spi_done;
  assign hdr_len   = 4'd4 + {3'd0, lcfg[25]} + {1'b0, lcfg[10:8]};
  assign last_hdr  = (hidx == hdr_len - 4'd1);
  assign last_byte = (bcnt == {BCNT_W{1'b1}});
  assign lane      = lcfg[26] ? ~bcnt[1:0] : bcnt[1:0];
  assign unused_bits = ^{rd_addr[1:0], lcfg[31:27], lcfg[24], lcfg[15:11]};

  always_comb begin
    wnext = wacc;
    wnext[{lane, 3'b000} +: 8] = spi_rx;
  end

  always_comb begin
    spi_tx = 8'h00;
    if (state == S_HDR) begin
      case (hidx)
        4'd0:    spi_tx = lcfg[7:0];
        4'd1:    spi_tx = fa_q[23:16];
        4'd2:    spi_tx = fa_q[15:8];
        4'd3:    spi_tx = fa_q[7:0];
        4'd4:    spi_tx = lcfg[25] ? lcfg[23:16] : 8'h00;
        default: spi_tx = 8'h00;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(xfer && (fa_q[ADDR_W-1:FA_BITS] == CSW'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cfg       <= CFG_RESET;
      lcfg      <= CFG_RESET;
      base      <= '0;
      base_ok   <= 1'b0;
      addr_q    <= '0;
      fa_q      <= '0;
      wait_done <= 1'b0;
      hidx      <= '0;
      bcnt      <= '0;
      wacc      <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (cfg_wr) cfg <= cfg_wdata;
      case (state)
        S_IDLE: begin
          if (accept) begin
            addr_q <= a_al;
            if (hit) begin
              rd_valid <= 1'b1;
            end else begin
              lcfg      <= cfg;
              fa_q      <= fa_new;
              hidx      <= '0;
              bcnt      <= '0;
              wait_done <= 1'b0;
              base_ok   <= 1'b0;
              state     <= S_HDR;
            end
          end
        end
        S_HDR: begin
          if (spi_start) wait_done <= 1'b1;
          if (got) begin
            wait_done <= 1'b0;
            if (last_hdr) state <= S_DATA;
            else hidx <= hidx + 4'd1;
          end
        end
        S_DATA: begin
          if (spi_start) wait_done <= 1'b1;
          if (got) begin
            wait_done <= 1'b0;
            wacc      <= wnext;
            bcnt      <= bcnt + 1'b1;
            if (last_byte) begin
              base    <= addr_q;
              base_ok <= 1'b1;
              state   <= S_RESP;
            end
          end
        end
        default: begin
          rd_valid <= 1'b1;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_DATA && got && bcnt[1:0] == 2'b11)
      mem[bcnt[BCNT_W-1:2]] <= wnext;
    if (accept && hit)
      rd_data <= mem[hit_idx];
    else if (state == S_RESP)
      rd_data <= mem[0];
  end
endmodule

module flash_line_buf_chk #(
  parameter int NUM_CS = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_ready,
  input logic              spi_start,
  input logic [NUM_CS-1:0] cs_n
);
  p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (cs_n == '1));
  p_cs_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_cs_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n != '1) && ($past(cs_n) != '1)) |-> $stable(cs_n));
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !rd_ready);
  p_one_xfer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |=> !spi_start);
endmodule

bind flash_line_buf flash_line_buf_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_ready(rd_ready),
  .spi_start(spi_start), .cs_n(cs_n));

// File: tb/flash_line_buf_tb.sv
`timescale 1ns/1ps
module flash_line_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        rd_req = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        rd_ready, rd_valid;
  logic [31:0] rd_data;
  logic        spi_start;
  logic [7:0]  spi_tx;
  logic        spi_done = 1'b0;
  logic [7:0]  spi_rx = '0;
  logic [3:0]  cs_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_line_buf u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .spi_start(spi_start),
    .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx), .cs_n(cs_n));

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return (a[7:0] * 8'd5 + a[15:8] * 8'd3 + a[23:16]) ^ 8'h5A;
  endfunction

  function automatic logic [31:0] expw(input logic [23:0] fa0, input int w, input bit be);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b = fbyte(fa0 + 24'(4 * w + i));
      if (be) r[8*(3-i) +: 8] = b;
      else    r[8*i +: 8] = b;
    end
    return r;
  endfunction

  // byte-level flash responder
  int         nb = 0;
  int         exp_hlen = 7;
  int         txn = 0;
  logic [7:0] hlog [16];
  logic [3:0] cs_seen = 4'hF;
  bit         pend = 0;
  logic [7:0] rxv = '0;

  always @(negedge clk) begin
    spi_done = 1'b0;
    if (cs_n == 4'hF) nb = 0;
    if (pend) begin
      spi_done = 1'b1;
      spi_rx = rxv;
      pend = 0;
    end
    if (rst_n && spi_start) begin
      if (nb == 0) begin
        txn++;
        cs_seen = cs_n;
      end
      if (nb < 16) hlog[nb] = spi_tx;
      if (nb < exp_hlen) rxv = 8'hEE;
      else rxv = fbyte({hlog[1], hlog[2], hlog[3]} + 24'(nb - exp_hlen));
      nb++;
      pend = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_req = 1'b1;
    rd_addr = a;
    while (!rd_ready) @(negedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    while (!rd_valid) @(negedge clk);
    d = rd_data;
  endtask

  task automatic wcfg(input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t0;
    repeat (4) @(negedge clk);
    chk(cs_n == 4'hF, "R10 reset selects", 32'(cs_n), 32'hF);
    chk(rd_ready == 1'b1, "R11 reset ready", 32'(rd_ready), 1);
    chk(rd_valid == 1'b0, "R3 reset valid", 32'(rd_valid), 0);
    rst_n = 1'b1;

    // default configuration miss
    exp_hlen = 7;
    t0 = txn;
    rd(32'h100, d);
    chk(txn == t0 + 1, "R3 first read misses", 32'(txn - t0), 1);
    chk(hlog[0] == 8'hEB, "R12 default command", 32'(hlog[0]), 32'hEB);
    chk({hlog[1], hlog[2], hlog[3]} == 24'h000100, "R4 address bytes",
        32'({hlog[1], hlog[2], hlog[3]}), 32'h100);
    chk(hlog[4] == 8'hA0, "R5 mode byte", 32'(hlog[4]), 32'hA0);
    chk(hlog[5] == 8'h00 && hlog[6] == 8'h00, "R6 dummy bytes",
        32'({hlog[5], hlog[6]}), 0);
    chk(cs_seen == 4'b1110, "R10 select 0", 32'(cs_seen), 32'hE);
    chk(cs_n == 4'hF, "R10 selects released", 32'(cs_n), 32'hF);
    chk(d == expw(24'h100, 0, 0), "R7 miss data", d, expw(24'h100, 0, 0));

    // full line sweep of hits
    t0 = txn;
    for (int w = 0; w < 256; w++) begin
      rd(32'h100 + 32'(4 * w), d);
      chk(d == expw(24'h100, w, 0), "R1 R7 hit word", d, expw(24'h100, w, 0));
    end
    chk(txn == t0, "R1 hits start no transaction", 32'(txn - t0), 0);
    rd(32'h100 + 32'd13, d);
    chk(d == expw(24'h100, 3, 0), "R2 low bits ignored", d, expw(24'h100, 3, 0));

    // edges of the line
    t0 = txn;
    rd(32'h500, d);
    chk(txn == t0 + 1, "R1 base plus 1024 misses", 32'(txn - t0), 1);
    chk(d == expw(24'h500, 0, 0), "R3 new base data", d, expw(24'h500, 0, 0));
    t0 = txn;
    rd(32'h4FC, d);
    chk(txn == t0 + 1, "R1 below base misses", 32'(txn - t0), 1);
    chk(d == expw(24'h4FC, 0, 0), "R3 lower base data", d, expw(24'h4FC, 0, 0));

    // no mode, no dummy, big endian
    wcfg(32'h0400_0003);
    exp_hlen = 4;
    t0 = txn;
    rd(32'h2000, d);
    chk(txn == t0 + 1, "R3 miss after config", 32'(txn - t0), 1);
    chk(hlog[0] == 8'h03, "R4 command from config", 32'(hlog[0]), 3);
    chk({hlog[1], hlog[2], hlog[3]} == 24'h002000, "R4 address order",
        32'({hlog[1], hlog[2], hlog[3]}), 32'h2000);
    chk(d == expw(24'h2000, 0, 1), "R5 R6 R8 short header", d, expw(24'h2000, 0, 1));
    for (int k = 0; k < 3; k++) begin
      int w = (k == 0) ? 1 : (k == 1) ? 100 : 255;
      rd(32'h2000 + 32'(4 * w), d);
      chk(d == expw(24'h2000, w, 1), "R8 big endian word", d, expw(24'h2000, w, 1));
    end

    // dual bus, mode byte 5C, one dummy, select 1
    wcfg(32'h425C_010B);
    exp_hlen = 6;
    rd(32'h0300_0040, d);
    chk(hlog[0] == 8'h0B, "R4 command", 32'(hlog[0]), 32'h0B);
    chk({hlog[1], hlog[2], hlog[3]} == 24'h800020, "R9 halved address",
        32'({hlog[1], hlog[2], hlog[3]}), 32'h800020);
    chk(hlog[4] == 8'h5C, "R5 programmed mode", 32'(hlog[4]), 32'h5C);
    chk(hlog[5] == 8'h00, "R6 single dummy", 32'(hlog[5]), 0);
    chk(cs_seen == 4'b1101, "R10 select 1", 32'(cs_seen), 32'hD);
    chk(d == expw(24'h800020, 0, 0), "R9 data", d, expw(24'h800020, 0, 0));
    rd(32'h0300_0048, d);
    chk(d == expw(24'h800020, 2, 0), "R9 hit word", d, expw(24'h800020, 2, 0));

    // request held across a refill
    t0 = txn;
    @(negedge clk);
    rd_req = 1'b1;
    rd_addr = 32'h0100_0000;
    while (!rd_ready) @(negedge clk);
    @(negedge clk);
    rd_addr = 32'h0100_0008;
    chk(rd_ready == 1'b0, "R11 ready low in refill", 32'(rd_ready), 0);
    while (!rd_ready) @(negedge clk);
    chk(rd_valid == 1'b1 && rd_data == expw(24'h800000, 0, 0), "R11 first answer",
        rd_data, expw(24'h800000, 0, 0));
    chk(cs_seen == 4'b1110, "R10 select 0 after halving", 32'(cs_seen), 32'hE);
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid == 1'b1 && rd_data == expw(24'h800000, 2, 0), "R11 held request served",
        rd_data, expw(24'h800000, 2, 0));
    chk(txn == t0 + 1, "R11 single transaction", 32'(txn - t0), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule